// File: doc/BRIEF.md
# Banked GPIO Event Interrupt Controller

This block watches a set of general-purpose input lines and raises a single interrupt when any of them shows the event it has been configured for. The lines are organised in banks of eight. Each line can detect a rising edge, a falling edge, any change, a high level or a low level. Each line can also be masked. Every pin first passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier.

Software drives a flat register port with a write strobe and a combinational read. The address is `bank*8 + sel`, so the bank sits in the upper address bits and the register select in the low three bits. The select values are:

| sel | Register | Access |
|-----|----------|--------|
| 0 | line enable | read/write |
| 1 | any-change select | read/write |
| 2 | level select | read/write |
| 3 | polarity | read/write |
| 4 | masked status (read) / clear (write) | read, write-one-to-clear |

Select values 5 to 7 and bank numbers with no bank behind them read as zero. Writes to them are ignored.

Edge events are latched until software clears them. A level-mode status bit instead tracks the qualified pin live. The interrupt output is the OR of every masked status bit in the block.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: Line n is reported in bank n/8 at bit n%8, in every register and in the status read. Register address = bank*8 + sel.
- R2: After a synchronous reset, every configuration register and every latched status bit is 0, and irq_o is 0.
- R3: When a line's any-change bit (sel 1) is 1, a rising or falling synchronised transition latches its status bit. Its level and polarity bits are ignored in that case.
- R4: With any-change 0, level bit (sel 2) 0 and polarity bit (sel 3) 1, only a rising transition latches status.
- R5: With any-change 0, level bit 0 and polarity bit 0, only a falling transition latches status.
- R6: With any-change 0 and level bit 1, the status bit equals (synchronised pin == polarity bit), live. A clear write has no effect on it.
- R7: The status read (sel 4) shows a line only when its enable bit (sel 0) is 1. An edge latched while disabled stays pending and appears once the line is enabled.
- R8: A write to sel 4 clears exactly the latched bits written as 1. Other bits keep their value.
- R9: An edge detected in the same cycle as a clear of its bit leaves the bit set.
- R10: irq_o is 1 exactly when at least one masked status bit in any bank is 1.
- R11: A pin change driven before clock edge k is first visible in level status after edge k+1. An edge it causes is first visible in the latched status after edge k+2.
- R12: The configuration registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NUM_BANKS*8 | Asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (bank*8 + sel) |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address (bank*8 + sel) |
| rd_data | output | 8 | Combinational read data |
| irq_o | output | 1 | Active-high combined interrupt |

## Verification
The bench builds the block with its default of three banks, which gives 24 lines and a five-bit address. With that value, lines in the first, middle and last bank can be driven, so the bank-to-bit mapping is tested at both ends of the address range. Every sense mode is exercised on lines in different banks. The clear is timed to land on the exact cycle an edge is latched, and the mask is shown holding back a pending edge until the line is enabled.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int BANK_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_EN    = 3'd0,
        SEL_BOTH  = 3'd1,
        SEL_SENSE = 3'd2,
        SEL_POL   = 3'd3,
        SEL_STAT  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [BANK_W-1:0] en;
        logic [BANK_W-1:0] both;
        logic [BANK_W-1:0] sense;
        logic [BANK_W-1:0] pol;
    } bank_cfg_t;

    // Single-line edge qualifier for an edge-mode line.
    function automatic logic edge_match(input logic pol, input logic cur, input logic prev);
        return pol ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_i;
            stage2 <= stage1;
        end
    end

    assign sync_o = stage2;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
(
    input  bank_cfg_t         cfg_i,
    input  logic [BANK_W-1:0] cur_i,
    input  logic [BANK_W-1:0] prev_i,
    output logic [BANK_W-1:0] edge_evt_o,
    output logic [BANK_W-1:0] lvl_sel_o,
    output logic [BANK_W-1:0] lvl_hit_o
);
    for (genvar i = 0; i < BANK_W; i++) begin : g_line
        logic any_change;
        logic single_edge;

        always_comb begin
            any_change  = cur_i[i] ^ prev_i[i];
            single_edge = edge_match(cfg_i.pol[i], cur_i[i], prev_i[i]);
            lvl_sel_o[i] = cfg_i.sense[i] & ~cfg_i.both[i];
            lvl_hit_o[i] = ~(cur_i[i] ^ cfg_i.pol[i]);
            if (cfg_i.both[i]) begin
                edge_evt_o[i] = any_change;
            end else if (!cfg_i.sense[i]) begin
                edge_evt_o[i] = single_edge;
            end else begin
                edge_evt_o[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] cur_i,
    input  logic              wr_hit_i,
    input  reg_sel_e          wr_sel_i,
    input  logic [BANK_W-1:0] wr_data_i,
    input  reg_sel_e          rd_sel_i,
    output logic [BANK_W-1:0] rd_data_o,
    output logic [BANK_W-1:0] masked_o,
    output bank_cfg_t         cfg_o,
    output logic [BANK_W-1:0] lat_o,
    output logic [BANK_W-1:0] prev_o,
    output logic [BANK_W-1:0] clr_o
);
    bank_cfg_t         cfg_q;
    logic [BANK_W-1:0] lat_q;
    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] edge_evt;
    logic [BANK_W-1:0] lvl_sel;
    logic [BANK_W-1:0] lvl_hit;
    logic [BANK_W-1:0] raw_stat;

    gpio_evt_detect u_det (
        .cfg_i      (cfg_q),
        .cur_i      (cur_i),
        .prev_i     (prev_q),
        .edge_evt_o (edge_evt),
        .lvl_sel_o  (lvl_sel),
        .lvl_hit_o  (lvl_hit)
    );

    // Clear mask for this cycle; zero unless the status slot is written.
    always_comb begin
        clr_o = '0;
        if (wr_hit_i && (wr_sel_i == SEL_STAT)) begin
            clr_o = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            lat_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= cur_i;
            // A fresh edge wins over a coincident clear.
            lat_q  <= (lat_q & ~clr_o) | edge_evt;
            if (wr_hit_i) begin
                unique case (wr_sel_i)
                    SEL_EN:    cfg_q.en    <= wr_data_i;
                    SEL_BOTH:  cfg_q.both  <= wr_data_i;
                    SEL_SENSE: cfg_q.sense <= wr_data_i;
                    SEL_POL:   cfg_q.pol   <= wr_data_i;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        for (int i = 0; i < BANK_W; i++) begin
            raw_stat[i] = lvl_sel[i] ? lvl_hit[i] : lat_q[i];
        end
        masked_o = raw_stat & cfg_q.en;
    end

    always_comb begin
        unique case (rd_sel_i)
            SEL_EN:    rd_data_o = cfg_q.en;
            SEL_BOTH:  rd_data_o = cfg_q.both;
            SEL_SENSE: rd_data_o = cfg_q.sense;
            SEL_POL:   rd_data_o = cfg_q.pol;
            SEL_STAT:  rd_data_o = masked_o;
            default:   rd_data_o = '0;
        endcase
    end

    assign cfg_o  = cfg_q;
    assign lat_o  = lat_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int  NUM_BANKS = 3,
    localparam int LINES     = NUM_BANKS * BANK_W,
    localparam int BANK_AW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = BANK_AW + SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  line_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BANK_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BANK_W-1:0] rd_data,
    output logic              irq_o
);
    logic [LINES-1:0]   cur_all;
    logic [LINES-1:0]   prev_all;
    logic [LINES-1:0]   lat_all;
    logic [LINES-1:0]   en_all;
    logic [LINES-1:0]   both_all;
    logic [LINES-1:0]   clr_all;
    logic [LINES-1:0]   masked_all;
    logic [BANK_W-1:0]  bank_rd [NUM_BANKS];

    logic [BANK_AW-1:0] wr_bank;
    logic [BANK_AW-1:0] rd_bank;
    reg_sel_e           wr_sel;
    reg_sel_e           rd_sel;

    assign wr_bank = wr_addr[ADDR_W-1:SEL_W];
    assign rd_bank = rd_addr[ADDR_W-1:SEL_W];
    assign wr_sel  = reg_sel_e'(wr_addr[SEL_W-1:0]);
    assign rd_sel  = reg_sel_e'(rd_addr[SEL_W-1:0]);

    gpio_sync #(.W(LINES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (line_i),
        .sync_o  (cur_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic      wr_hit;
        bank_cfg_t cfg;

        assign wr_hit = wr_en && (wr_bank == BANK_AW'(b));

        gpio_evt_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .cur_i     (cur_all[b*BANK_W +: BANK_W]),
            .wr_hit_i  (wr_hit),
            .wr_sel_i  (wr_sel),
            .wr_data_i (wr_data),
            .rd_sel_i  (rd_sel),
            .rd_data_o (bank_rd[b]),
            .masked_o  (masked_all[b*BANK_W +: BANK_W]),
            .cfg_o     (cfg),
            .lat_o     (lat_all[b*BANK_W +: BANK_W]),
            .prev_o    (prev_all[b*BANK_W +: BANK_W]),
            .clr_o     (clr_all[b*BANK_W +: BANK_W])
        );

        assign en_all[b*BANK_W +: BANK_W]   = cfg.en;
        assign both_all[b*BANK_W +: BANK_W] = cfg.both;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank == BANK_AW'(b)) begin
                rd_data = bank_rd[b];
            end
        end
    end

    assign irq_o = |masked_all;
endmodule

// File: rtl/gpio_evt_ctrl_chk.sv
module gpio_evt_ctrl_chk #(
    parameter int LINES = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_o,
    input logic [LINES-1:0] en_all,
    input logic [LINES-1:0] both_all,
    input logic [LINES-1:0] cur_all,
    input logic [LINES-1:0] prev_all,
    input logic [LINES-1:0] lat_all,
    input logic [LINES-1:0] clr_all
);
    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_o && (lat_all == '0) && (en_all == '0)));

    // R8
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((($past(lat_all) & ~lat_all) & ~$past(clr_all)) == '0));

    // R3, R9
    both_catch_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((($past(cur_all) ^ $past(prev_all)) & $past(both_all) & ~lat_all) == '0));

    // R7, R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (en_all == '0) |-> !irq_o);
endmodule

bind gpio_evt_ctrl gpio_evt_ctrl_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_o    (irq_o),
    .en_all   (en_all),
    .both_all (both_all),
    .cur_all  (cur_all),
    .prev_all (prev_all),
    .lat_all  (lat_all),
    .clr_all  (clr_all)
);

// File: tb/sim_gpio_evt_ctrl.sv
module sim_gpio_evt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;
    localparam int NL = NB * 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] pins = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          irq_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_evt_ctrl #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst(rst), .line_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    // Behavioural reference state
    logic [7:0]    m_en [NB];
    logic [7:0]    m_both [NB];
    logic [7:0]    m_sense [NB];
    logic [7:0]    m_pol [NB];
    logic [7:0]    m_lat [NB];
    logic [NL-1:0] m_s1, m_s2, m_prev;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status(input int b);
        logic [7:0] s;
        for (int i = 0; i < 8; i++) begin
            if (m_sense[b][i] && !m_both[b][i]) s[i] = (m_s2[b*8+i] == m_pol[b][i]);
            else s[i] = m_lat[b][i];
        end
        return s & m_en[b];
    endfunction

    function automatic logic [7:0] m_read(input logic [AW-1:0] a);
        int b = int'(a[AW-1:3]);
        int s = int'(a[2:0]);
        if (b >= NB) return 8'h00;
        case (s)
            0: return m_en[b];
            1: return m_both[b];
            2: return m_sense[b];
            3: return m_pol[b];
            4: return m_status(b);
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit m_irq();
        bit r = 0;
        for (int b = 0; b < NB; b++) r |= (m_status(b) != 0);
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                m_en[b] = 0; m_both[b] = 0; m_sense[b] = 0; m_pol[b] = 0; m_lat[b] = 0;
            end
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                logic [7:0] evt;
                logic [7:0] clr;
                for (int i = 0; i < 8; i++) begin
                    logic c, p;
                    c = m_s2[b*8+i];
                    p = m_prev[b*8+i];
                    if (m_both[b][i]) evt[i] = (c != p);
                    else if (!m_sense[b][i]) evt[i] = m_pol[b][i] ? (c && !p) : (!c && p);
                    else evt[i] = 0;
                end
                clr = (wr_en && int'(wr_addr[AW-1:3]) == b && wr_addr[2:0] == 3'd4) ? wr_data : 8'h00;
                m_lat[b] = (m_lat[b] & ~clr) | evt;
                if (wr_en && int'(wr_addr[AW-1:3]) == b) begin
                    case (wr_addr[2:0])
                        3'd0: m_en[b] = wr_data;
                        3'd1: m_both[b] = wr_data;
                        3'd2: m_sense[b] = wr_data;
                        3'd3: m_pol[b] = wr_data;
                        default: ;
                    endcase
                end
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        end
        #1;
        if (!done) begin
            check(rd_data == m_read(rd_addr), (rd_addr[2:0] == 3'd4) ? "R7 model status" : "R12 model cfg",
                  int'(rd_data), int'(m_read(rd_addr)));
            check(irq_o == m_irq(), "R10 model irq", int'(irq_o), int'(m_irq()));
        end
    end

    function automatic logic [AW-1:0] A(input int bank, input int sel);
        return AW'(bank*8 + sel);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setpin(input int n, input logic v);
        @(negedge clk);
        pins[n] = v;
    endtask

    task automatic chk_rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data == exp, tag, int'(rd_data), int'(exp));
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        check(irq_o == exp, tag, int'(irq_o), int'(exp));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R2: reset state
        chk_rd(A(0,4), 8'h00, "R2 status bank0");
        chk_rd(A(2,4), 8'h00, "R2 status bank2");
        chk_rd(A(1,0), 8'h00, "R2 enable bank1");
        chk_irq(1'b0, "R2 irq");

        // R12: readback
        wr(A(1,0), 8'hA5);
        chk_rd(A(1,0), 8'hA5, "R12 enable readback");
        wr(A(1,0), 8'h00);

        // R4 / R11: rising on line 3
        wr(A(0,0), 8'h08);
        wr(A(0,3), 8'h08);
        rd_addr = A(0,4);
        setpin(3, 1'b1);
        step(2);
        chk_rd(A(0,4), 8'h00, "R11 edge not yet visible");
        step(1);
        chk_rd(A(0,4), 8'h08, "R4 rising latched");
        chk_irq(1'b1, "R10 irq from bank0");
        setpin(3, 1'b0);
        step(3);
        chk_rd(A(0,4), 8'h08, "R4 falling ignored");
        wr(A(0,4), 8'h00);
        chk_rd(A(0,4), 8'h08, "R8 zero clear keeps bit");
        wr(A(0,4), 8'h08);
        chk_rd(A(0,4), 8'h00, "R8 clear drops bit");
        chk_irq(1'b0, "R10 irq low after clear");

        // R5: falling on line 10
        wr(A(1,0), 8'h04);
        setpin(10, 1'b1);
        step(3);
        chk_rd(A(1,4), 8'h00, "R5 rising ignored");
        setpin(10, 1'b0);
        step(3);
        chk_rd(A(1,4), 8'h04, "R5 falling latched");
        wr(A(1,4), 8'h04);
        chk_rd(A(1,4), 8'h00, "R8 clear bank1");

        // R3 / R1: any-change on line 20, level and polarity set but ignored
        wr(A(2,2), 8'h10);
        wr(A(2,3), 8'h10);
        wr(A(2,1), 8'h10);
        wr(A(2,0), 8'h10);
        setpin(20, 1'b1);
        step(3);
        chk_rd(A(2,4), 8'h10, "R1 line20 at bank2 bit4 rising");
        wr(A(2,4), 8'h10);
        chk_rd(A(2,4), 8'h00, "R3 level bit ignored while pin high");
        setpin(20, 1'b0);
        step(3);
        chk_rd(A(2,4), 8'h10, "R3 falling caught");
        wr(A(2,4), 8'h10);

        // R6: level high on line 5
        wr(A(0,2), 8'h20);
        wr(A(0,3), 8'h28);
        wr(A(0,0), 8'h28);
        chk_rd(A(0,4), 8'h00, "R6 level high idle");
        setpin(5, 1'b1);
        step(1);
        chk_rd(A(0,4), 8'h00, "R11 level after one edge");
        step(1);
        chk_rd(A(0,4), 8'h20, "R6 level high live");
        wr(A(0,4), 8'h20);
        chk_rd(A(0,4), 8'h20, "R6 clear has no effect");
        setpin(5, 1'b0);
        step(2);
        chk_rd(A(0,4), 8'h00, "R6 level follows pin low");

        // R6: level low on line 6
        wr(A(0,2), 8'h60);
        wr(A(0,0), 8'h68);
        chk_rd(A(0,4), 8'h40, "R6 level low active");
        setpin(6, 1'b1);
        step(2);
        chk_rd(A(0,4), 8'h00, "R6 level low released");
        setpin(6, 1'b0);
        step(2);
        chk_rd(A(0,4), 8'h40, "R6 level low again");
        wr(A(0,0), 8'h08);

        // R7: masked edge stays pending
        wr(A(0,3), 8'h2A);
        setpin(1, 1'b1);
        step(3);
        chk_rd(A(0,4), 8'h00, "R7 masked line hidden");
        chk_irq(1'b0, "R7 masked irq low");
        wr(A(0,0), 8'h0A);
        chk_rd(A(0,4), 8'h02, "R7 pending appears on enable");
        chk_irq(1'b1, "R10 irq on enable");
        wr(A(0,4), 8'h02);

        // R9: clear coincident with edge on line 16
        wr(A(2,1), 8'h11);
        wr(A(2,0), 8'h11);
        setpin(16, 1'b1);
        step(3);
        chk_rd(A(2,4), 8'h01, "R3 line16 rising");
        setpin(16, 1'b0);
        step(1);
        wr(A(2,4), 8'h01);
        chk_rd(A(2,4), 8'h01, "R9 edge wins over clear");
        chk_irq(1'b1, "R10 irq from bank2");
        wr(A(2,4), 8'h01);
        chk_rd(A(2,4), 8'h00, "R8 later clear works");
        chk_irq(1'b0, "R10 irq idle");

        step(2);
        finish_run();
    end
endmodule